// File: doc/BRIEF.md
# Float32 Compare Flag Unit

This block executes one kind of instruction: a compare of two single-precision IEEE-754 values held in a bank of four 32-bit operand registers. When a valid instruction word carries the compare opcode, two 2-bit fields in the word pick the operands. The block orders them as real numbers and writes the outcome into two flags of a five-flag status register: a zero flag and a negative flag. The other three flags keep their values.

The compare needs no floating-point subtractor. Each operand is first made canonical: a denormal becomes a zero of the same sign, and a negative zero becomes a positive zero. The canonical pattern is then mapped to an unsigned key. A positive value has its top bit set. A negative value has all of its bits inverted. One unsigned magnitude compare of the two keys gives the order. Operands are loaded through a register write port. The status register can be loaded as a whole through a flag preload port, which stands in for the other instructions that own the three untouched flags.

Top module: `fcmp_flag_unit`

## Requirements
- R1: An asynchronous active-low reset clears all five status bits and all four operand registers to zero. Reset release is synchronised inside the block.
- R2: A word is a compare only when `instr_valid` is high, bits 31:16 equal 16'h7D00, and bits 15:4 are all zero. Any other word, or a cycle with `instr_valid` low, leaves the status unchanged.
- R3: Instruction bits 1:0 select operand A and bits 3:2 select operand B, from registers 0 to 3.
- R4: When A equals B, the zero flag becomes 1 and the negative flag becomes 0.
- R5: When A is greater than B, the zero flag and the negative flag both become 0.
- R6: When A is less than B, the zero flag becomes 0 and the negative flag becomes 1.
- R7: The status bit positions are: bit 0 test, bit 1 zero, bit 2 negative, bit 3 underflow, bit 4 overflow. A compare never changes bits 0, 3 and 4.
- R8: The flags show the compare result right after the rising edge that samples the instruction, which is a latency of one cycle.
- R9: Ordering goes by sign first. Any negative value is less than any positive value. Between two negatives, the one with the larger magnitude is the lesser, so -1.0 (0xBF800000) is greater than -2.0 (0xC0000000).
- R10: +0 and -0 compare equal. An operand whose exponent field (bits 30:23) is zero is treated as a zero of its own sign.
- R11: `reg_wr_en` writes `reg_wr_data` into register `reg_wr_sel` on the clock edge. A compare in the same cycle reads the value held before that write.
- R12: `flag_ld_en` loads `flag_ld_data` into all five status bits. When a compare fires in the same cycle, the compare result takes bits 1 and 2 and the loaded value takes the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| reg_wr_en | input | 1 | Operand register write enable |
| reg_wr_sel | input | 2 | Operand register index to write |
| reg_wr_data | input | 32 | Operand register write data |
| flag_ld_en | input | 1 | Status register load enable |
| flag_ld_data | input | 5 | Status register load value |
| status_q | output | 5 | Status register: bit 0 test, bit 1 zero, bit 2 negative, bit 3 underflow, bit 4 overflow |

## Verification
The only state visible at the ports is the status register. An operand register holding a wrong value stays hidden until a compare reads it. From that point the wrong ordering shows in bits 1 and 2 one edge after the instruction. For this reason the random stimulus keeps copying existing register contents and signed zeros into the bank, so that equal and near-equal pairs come up often. A wrong decode or a wrong enable on the status register shows up in the very next cycle as a flag that moved when it should have held, or held when it should have moved. That includes the three preserved bits after a preload.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned FLAG_CNT  = 5;
  localparam int unsigned FLG_TEST  = 0;
  localparam int unsigned FLG_ZERO  = 1;
  localparam int unsigned FLG_NEG   = 2;
  localparam int unsigned FLG_UNDER = 3;
  localparam int unsigned FLG_OVER  = 4;

  localparam logic [15:0] CMP_OPCODE_HI = 16'h7D00;

  typedef logic [FLAG_CNT-1:0] flags_t;

  typedef struct packed {
    logic eq;
    logic lt;
  } order_t;
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  output logic              cmp_fire,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b
);
  import fcmp_pkg::*;

  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned SEL_HI = 2 * SEL_W;

  logic opc_match;
  logic pad_zero;

  always_comb begin
    opc_match = (instr_word[WORD_W-1:HALF_W] == CMP_OPCODE_HI);
    pad_zero  = (instr_word[HALF_W-1:SEL_HI] == '0);
    cmp_fire  = instr_valid && opc_match && pad_zero;
    sel_a     = instr_word[SEL_W-1:0];
    sel_b     = instr_word[SEL_HI-1:SEL_W];
  end
endmodule

// File: rtl/fcmp_regbank.sv
module fcmp_regbank #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_CNT = 4,
  localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] bank_q [REG_CNT];
  logic [REG_CNT-1:0] bank_en;

  always_comb begin
    for (int i = 0; i < REG_CNT; i++) begin
      bank_en[i] = wr_en && (wr_sel == SEL_W'(i));
    end
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (bank_en[g]) begin
        bank_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_a = bank_q[rd_sel_a];
    rd_b = bank_q[rd_sel_b];
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_one_write_R11: assert ($onehot0(bank_en));
    end
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output fcmp_pkg::order_t  order
);
  logic [DATA_W-1:0] canon_a, canon_b;
  logic [DATA_W-1:0] key_a, key_b;

  function automatic logic [DATA_W-1:0] canonical(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = v;
    if (v[DATA_W-2:MAN_W] == '0) begin
      r[MAN_W-1:0] = '0;
    end
    if (r[DATA_W-2:0] == '0) begin
      r[DATA_W-1] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] order_key(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    if (v[DATA_W-1]) begin
      r = ~v;
    end else begin
      r = v;
      r[DATA_W-1] = 1'b1;
    end
    return r;
  endfunction

  always_comb begin
    canon_a  = canonical(op_a);
    canon_b  = canonical(op_b);
    key_a    = order_key(canon_a);
    key_b    = order_key(canon_b);
    order.eq = (key_a == key_b);
    order.lt = (key_a < key_b);
  end

  always_comb begin
    assert_order_excl_R4: assert (!(order.eq && order.lt));
  end
endmodule

// File: rtl/fcmp_status.sv
module fcmp_status (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_fire,
  input  fcmp_pkg::order_t  order,
  input  logic              ld_en,
  input  fcmp_pkg::flags_t  ld_data,
  output fcmp_pkg::flags_t  flags_q
);
  import fcmp_pkg::*;

  flags_t flags_d;
  logic   flags_en;

  always_comb begin
    flags_d = flags_q;
    if (ld_en) begin
      flags_d = ld_data;
    end
    if (cmp_fire) begin
      flags_d[FLG_ZERO] = order.eq;
      flags_d[FLG_NEG]  = order.lt;
    end
    flags_en = ld_en || cmp_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_fire || ld_en) |=> $stable(flags_q));

  assert_flag_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !(flags_q[FLG_ZERO] && flags_q[FLG_NEG]));

  assert_keep_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && !ld_en) |=> flags_q[FLG_TEST] == $past(flags_q[FLG_TEST]));

  assert_keep_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && !ld_en) |=> flags_q[FLG_OVER:FLG_UNDER] == $past(flags_q[FLG_OVER:FLG_UNDER]));

  assert_preload_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !cmp_fire) |=> flags_q == $past(ld_data));

  assert_less_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && order.lt) |=> flags_q[FLG_NEG] && !flags_q[FLG_ZERO]);
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned MAN_W   = 23,
  parameter int unsigned REG_CNT = 4,
  localparam int unsigned DATA_W = 1 + EXP_W + MAN_W,
  localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic              reg_wr_en,
  input  logic [SEL_W-1:0]  reg_wr_sel,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              flag_ld_en,
  input  logic [4:0]        flag_ld_data,
  output logic [4:0]        status_q
);
  import fcmp_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              cmp_fire;
  logic [SEL_W-1:0]  sel_a, sel_b;
  logic [DATA_W-1:0] op_a, op_b;
  order_t            order;
  flags_t            flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  fcmp_decode #(.WORD_W(32), .SEL_W(SEL_W)) u_decode (
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .cmp_fire    (cmp_fire),
    .sel_a       (sel_a),
    .sel_b       (sel_b)
  );

  fcmp_regbank #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr_en),
    .wr_sel   (reg_wr_sel),
    .wr_data  (reg_wr_data),
    .rd_sel_a (sel_a),
    .rd_sel_b (sel_b),
    .rd_a     (op_a),
    .rd_b     (op_b)
  );

  fcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .op_a  (op_a),
    .op_b  (op_b),
    .order (order)
  );

  fcmp_status u_status (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmp_fire (cmp_fire),
    .order    (order),
    .ld_en    (flag_ld_en),
    .ld_data  (flag_ld_data),
    .flags_q  (flags_q)
  );

  assign status_q = flags_q;

  assert_same_bits_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmp_fire && op_a == op_b) |=> status_q[FLG_ZERO] && !status_q[FLG_NEG]);

  assert_sign_first_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmp_fire && op_a[DATA_W-1] && !op_b[DATA_W-1] && op_a[DATA_W-2:MAN_W] != '0)
      |=> status_q[FLG_NEG]);
endmodule

// File: tb/test_fcmp_flag_unit.sv
module test_fcmp_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic        flag_ld_en = 1'b0;
  logic [4:0]  flag_ld_data = '0;
  logic [4:0]  status_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_reg [4];
  logic [4:0]  m_flags;

  always #10 clk = ~clk;

  fcmp_flag_unit i_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .flag_ld_en(flag_ld_en), .flag_ld_data(flag_ld_data), .status_q(status_q)
  );

  // Reference order: returns {neg, zero} using sign/magnitude reasoning.
  function automatic logic [1:0] ref_order(input logic [31:0] a, input logic [31:0] b);
    logic sa, sb;
    logic [30:0] ma, mb;
    sa = a[31]; ma = (a[30:23] == 0) ? 31'd0 : a[30:0];
    sb = b[31]; mb = (b[30:23] == 0) ? 31'd0 : b[30:0];
    if (ma == 0) sa = 0;
    if (mb == 0) sb = 0;
    if (sa == sb && ma == mb) return 2'b01;
    if (sa != sb) return sa ? 2'b10 : 2'b00;
    if (!sa) return (ma < mb) ? 2'b10 : 2'b00;
    return (ma > mb) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [31:0] enc(input logic [1:0] a, input logic [1:0] b);
    return {16'h7D00, 12'h000, b, a};
  endfunction

  function automatic string tag_of(input logic [1:0] r);
    if (r == 2'b01) return "R4";
    if (r == 2'b10) return "R6";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %b expected %b", tag, got, exp);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, then compare at the ports.
  task automatic step(input bit iv, input logic [31:0] iw, input bit we, input logic [1:0] ws,
                      input logic [31:0] wd, input bit le, input logic [4:0] ld, input string tag);
    logic [4:0] nxt;
    logic [1:0] r;
    instr_valid = iv; instr_word = iw; reg_wr_en = we; reg_wr_sel = ws;
    reg_wr_data = wd; flag_ld_en = le; flag_ld_data = ld;
    nxt = m_flags;
    if (le) nxt = ld;
    if (iv && iw[31:16] == 16'h7D00 && iw[15:4] == 0) begin
      r = ref_order(m_reg[iw[1:0]], m_reg[iw[3:2]]);
      nxt[1] = r[0];
      nxt[2] = r[1];
    end
    if (we) m_reg[ws] = wd;
    m_flags = nxt;
    @(posedge clk);
    #2;
    instr_valid = 0; reg_wr_en = 0; flag_ld_en = 0;
    check(tag, status_q, m_flags);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    step(0, 0, 1, s, d, 0, 0, "R11");
  endtask

  task automatic cmp(input logic [1:0] a, input logic [1:0] b, input string tag);
    step(1, enc(a, b), 0, 0, 0, 0, 0, tag);
  endtask

  function automatic logic [31:0] rand_val();
    int k;
    k = $urandom_range(0, 5);
    case (k)
      0: return {$urandom_range(0, 1) == 1, 31'd0};
      1: return {$urandom_range(0, 1) == 1, 8'd0, 23'($urandom)};
      2: return m_reg[$urandom_range(0, 3)];
      3: return m_reg[$urandom_range(0, 3)] ^ 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_flags = '0;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1", status_q, 5'b00000);
    cmp(2'd0, 2'd3, "R1");           // cleared registers compare equal
    cmp(2'd1, 2'd2, "R1");

    // Example operands from the requirements
    wr(2'd1, 32'hC000_0000);
    wr(2'd0, 32'h40A0_0000);
    cmp(2'd1, 2'd0, "R6");
    cmp(2'd0, 2'd1, "R5");
    cmp(2'd0, 2'd0, "R4");
    cmp(2'd1, 2'd0, "R3");           // selects in bits 1:0 and 3:2

    // Two negatives, sign ordering
    wr(2'd2, 32'hBF80_0000);
    cmp(2'd2, 2'd1, "R9");           // -1 > -2
    cmp(2'd1, 2'd2, "R9");
    cmp(2'd2, 2'd0, "R9");

    // Signed zeros and denormals
    wr(2'd2, 32'h8000_0000);
    wr(2'd3, 32'h0000_0000);
    cmp(2'd2, 2'd3, "R10");
    wr(2'd3, 32'h0000_0001);
    cmp(2'd3, 2'd2, "R10");
    wr(2'd2, 32'h8000_0005);
    cmp(2'd2, 2'd3, "R10");
    cmp(2'd2, 2'd1, "R10");          // neg denormal (zero) > -2

    // Preserve the other three flags
    step(0, 0, 0, 0, 0, 1, 5'b11111, "R12");
    cmp(2'd0, 2'd1, "R7");
    step(0, 0, 0, 0, 0, 1, 5'b01001, "R12");
    cmp(2'd1, 2'd0, "R7");
    step(1, enc(2'd0, 2'd0), 0, 0, 0, 1, 5'b10100, "R12");  // same-cycle load and compare

    // Non-matching words and invalid strobe
    step(1, 32'h7D00_0010, 0, 0, 0, 0, 0, "R2");
    step(1, 32'h7D01_0001, 0, 0, 0, 0, 0, "R2");
    step(0, enc(2'd1, 2'd0), 0, 0, 0, 0, 0, "R2");
    cmp(2'd1, 2'd0, "R8");           // flags move on the very next edge

    // Write and compare in the same cycle sees the old value
    step(1, enc(2'd0, 2'd1), 1, 2'd0, 32'hFF80_0000, 0, 0, "R11");
    cmp(2'd0, 2'd1, "R11");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      int kind;
      logic [1:0] a, b;
      logic [1:0] r;
      kind = $urandom_range(0, 9);
      a = 2'($urandom); b = 2'($urandom);
      r = ref_order(m_reg[a], m_reg[b]);
      if (kind < 4) begin
        wr(2'($urandom), rand_val());
      end else if (kind == 4) begin
        step(0, 0, 0, 0, 0, 1, 5'($urandom), "R12");
      end else if (kind == 5) begin
        step(1, enc(a, b) | (32'h1 << $urandom_range(4, 31)), 0, 0, 0, 0, 0, "R2");
      end else if (kind == 6) begin
        step(1, enc(a, b), 1, 2'($urandom), rand_val(), $urandom_range(0, 1) == 1,
             5'($urandom), "R12");
      end else begin
        cmp(a, b, tag_of(r));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule